// File: doc/BRIEF.md
# Four-Channel Down-Counter Timer

This block holds four independent down-counters that share a single clock and a simple synchronous register bus. Each channel has a control word, a current count, and a reload value held in the background. The control word turns the channel on and off. It picks one of three count-rate dividers, a 16-bit or a 32-bit count width, and one of three behaviours at the end of a count: the count wraps and keeps going, the count reloads from the background value, or the channel stops after one pass. Software loads a count, writes the control word, and then waits for the interrupt.

Every channel reports its end-of-count event as a raw status bit. The raw bits pass through a shared enable mask and are combined into one interrupt line. Software clears raw bits by writing ones to a clear register. A bus access takes one cycle. Read data is registered and is valid in the cycle after the read strobe.

Top module: `tmr4_top`

## Requirements
- R1: After synchronous reset, all of the following read as zero: the mask, raw and masked status, every count, control word and background value, and the read-data output. The interrupt output is low.
- R2: Addressing uses bus_addr[7:4] as the block index. Block 0 holds the shared registers: mask at 0x0, raw at 0x4, masked at 0x8 and clear at 0xC. Blocks 1..4 are channels 0..3. Within a channel, offset 0x0 is the load register, whose reads return the current count. Offset 0x4 is the current count, 0x8 is the control word (8 bits) and 0xC is the background value. Read data appears on bus_rdata one cycle after bus_rd. When control bit 1 is clear, a count read returns only its low 16 bits. Writes to the raw or masked offsets are ignored. Writes whose bus_addr[1:0] is nonzero are ignored.
- R3: When control bit 7 is set, the count drops by one on each count tick. The first tick comes at the first qualifying clock edge after the control write. A control write does not change the count.
- R4: Control bits 3:2 set the tick rate. Code 00 gives a tick on every cycle, 01 on every 16th cycle, and 10 or 11 on every 256th cycle. The cycles are counted from the last control write.
- R5: In free-running mode (bits 6 and 0 both clear), a tick at a count of zero sets the count to all ones for the selected width (0xFFFFFFFF or 0xFFFF) and sets the channel's raw bit.
- R6: In periodic mode (bit 6 set, bit 0 clear), a tick at a count of zero reloads the count from the background value and sets the raw bit.
- R7: A load write sets the count in the next cycle, even while the channel runs. A background write leaves the running count untouched.
- R8: In one-shot mode (bit 0 set), a tick at a count of 1 or 0 leaves the count at 0, sets the raw bit, and clears control bit 7. One-shot mode takes priority over bit 6.
- R9: Writing zero to the control word freezes the count. A tick that coincides with that write is dropped. The load register can still be written while the channel is stopped.
- R10: Masked status is raw AND mask. The interrupt output is the OR of the masked bits, one cycle later.
- R11: Writing the clear register clears exactly the raw bits written as 1 and leaves all other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the bus is synchronous to clk and that every strobe and address is at a known level whenever reset is low. They also assume that a single write never targets more than one register. The stimulus drives every input at the falling edge and raises at most one strobe per access. It uses only aligned addresses, apart from one deliberate misaligned write. Before each rate, mode or status test, the bench stops the channel and then reloads it, so that every count and status check starts from a known state.

// File: rtl/tmr4_pkg.sv
package tmr4_pkg;
  localparam int CTRL_W  = 8;
  localparam int CB_ONE  = 0;
  localparam int CB_WIDE = 1;
  localparam int CB_PRE  = 2;
  localparam int CB_PER  = 6;
  localparam int CB_EN   = 7;
  localparam int DIV_MID = 16;
  localparam int DIV_HI  = 256;

  typedef enum logic [1:0] {
    R_LOAD = 2'd0, R_VAL = 2'd1, R_CTRL = 2'd2, R_BG = 2'd3
  } chreg_e;

  typedef enum logic [1:0] {
    S_MASK = 2'd0, S_RAW = 2'd1, S_MIS = 2'd2, S_CLR = 2'd3
  } shreg_e;
endpackage

// File: rtl/tmr4_prescale.sv
module tmr4_prescale
  import tmr4_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int CW = $clog2(DIV_HI);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      2'b00:   limit = '0;
      2'b01:   limit = CW'(DIV_MID - 1);
      default: limit = CW'(DIV_HI - 1);
    endcase
  end

  assign tick = run && !restart && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (cnt == limit)      cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != 2'b00) |=> !tick);
endmodule

// File: rtl/tmr4_channel.sv
module tmr4_channel
  import tmr4_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              bg_we,
  input  logic              ctrl_we,
  input  logic [DW-1:0]     wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DW-1:0]     val_rd,
  output logic [DW-1:0]     bg_q,
  output logic              evt
);
  localparam int HALF = DW / 2;
  localparam logic [DW-1:0] HALF_MASK = {{(DW-HALF){1'b0}}, {HALF{1'b1}}};

  logic [DW-1:0] val_q;
  logic [DW-1:0] lowmask;
  logic [DW-1:0] cur;
  logic          step;
  logic          oneshot;
  logic          periodic;
  logic          end_hit;

  tmr4_prescale u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q[CB_EN]),
    .restart (ctrl_we),
    .sel     (ctrl_q[CB_PRE+1:CB_PRE]),
    .tick    (step)
  );

  assign lowmask  = ctrl_q[CB_WIDE] ? {DW{1'b1}} : HALF_MASK;
  assign cur      = val_q & lowmask;
  assign oneshot  = ctrl_q[CB_ONE];
  assign periodic = ctrl_q[CB_PER] && !oneshot;
  assign end_hit  = oneshot ? (cur <= DW'(1)) : (cur == '0);
  assign evt      = step && end_hit && !ld_we;
  assign val_rd   = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      bg_q   <= '0;
      val_q  <= '0;
    end else begin
      if (ctrl_we)              ctrl_q        <= wdata[CTRL_W-1:0];
      else if (evt && oneshot)  ctrl_q[CB_EN] <= 1'b0;
      if (bg_we) bg_q <= wdata;
      if (ld_we) begin
        val_q <= wdata;
      end else if (step) begin
        if (end_hit) begin
          if (oneshot)       val_q <= '0;
          else if (periodic) val_q <= bg_q & lowmask;
          else               val_q <= lowmask;
        end else begin
          val_q <= cur - 1'b1;
        end
      end
    end
  end

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && ctrl_q[CB_ONE] && !ctrl_we) |=> !ctrl_q[CB_EN]);
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && !ctrl_q[CB_ONE] && !ctrl_q[CB_PER]) |=> val_q == $past(lowmask));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !ld_we) |=> $stable(val_q));
endmodule

// File: rtl/tmr4_irq.sv
module tmr4_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt,
  input  logic           mask_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] raw_q,
  output logic           irq_o
);
  logic [NCH-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      raw_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      raw_q <= (raw_q & ~clr_bits) | evt;
      irq_o <= |(raw_q & mask_q);
    end
  end

  // R11
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> (raw_q & $past(wdata & ~evt)) == '0);
  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & mask_q) == '0) |=> !irq_o);
endmodule

// File: rtl/tmr4_top.sv
module tmr4_top
  import tmr4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int BW = AW - 4;

  logic [BW-1:0]     blk;
  logic [1:0]        rsel;
  logic              aligned;
  logic              sh_wr;
  logic [NCH-1:0]    evt;
  logic [NCH-1:0]    mask_q;
  logic [NCH-1:0]    raw_q;
  logic [CTRL_W-1:0] ctrl_a [NCH];
  logic [DW-1:0]     val_a  [NCH];
  logic [DW-1:0]     bg_a   [NCH];
  logic [DW-1:0]     rd_mux;

  assign blk     = bus_addr[AW-1:4];
  assign rsel    = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign sh_wr   = bus_wr && aligned && (blk == '0);

  for (genvar i = 0; i < NCH; i++) begin : gen_ch
    localparam logic [BW-1:0] MYBLK = BW'(i + 1);
    logic hit;
    assign hit = bus_wr && aligned && (blk == MYBLK);
    tmr4_channel #(.DW(DW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .ld_we   (hit && rsel == R_LOAD),
      .bg_we   (hit && rsel == R_BG),
      .ctrl_we (hit && rsel == R_CTRL),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_a[i]),
      .val_rd  (val_a[i]),
      .bg_q    (bg_a[i]),
      .evt     (evt[i])
    );
  end

  tmr4_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .mask_we (sh_wr && rsel == S_MASK),
    .clr_we  (sh_wr && rsel == S_CLR),
    .wdata   (bus_wdata[NCH-1:0]),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .irq_o   (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (blk == '0) begin
      case (rsel)
        S_MASK:  rd_mux = DW'(mask_q);
        S_RAW:   rd_mux = DW'(raw_q);
        S_MIS:   rd_mux = DW'(raw_q & mask_q);
        default: rd_mux = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (blk == BW'(i + 1)) begin
        case (rsel)
          R_CTRL:  rd_mux = DW'(ctrl_a[i]);
          R_BG:    rd_mux = bg_a[i];
          default: rd_mux = val_a[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/tb_tmr4_top.sv
`timescale 1ns/1ps
module tb_tmr4_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  tmr4_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {write addr, write data, read addr, expected}
  localparam logic [79:0] VECS [12] = '{
    {8'h00, 32'h0000_0005, 8'h00, 32'h0000_0005},
    {8'h10, 32'h1234_5678, 8'h14, 32'h0000_5678},
    {8'h1C, 32'hABCD_EF01, 8'h1C, 32'hABCD_EF01},
    {8'h18, 32'h0000_0002, 8'h14, 32'h1234_5678},
    {8'h18, 32'h0000_004C, 8'h18, 32'h0000_004C},
    {8'h18, 32'h0000_0000, 8'h18, 32'h0000_0000},
    {8'h04, 32'h0000_000F, 8'h04, 32'h0000_0000},
    {8'h08, 32'h0000_000F, 8'h08, 32'h0000_0000},
    {8'h00, 32'h0000_0000, 8'h00, 32'h0000_0000},
    {8'h2C, 32'h0000_0033, 8'h2C, 32'h0000_0033},
    {8'h40, 32'h0000_BEEF, 8'h44, 32'h0000_BEEF},
    {8'h41, 32'h0000_FFFF, 8'h40, 32'h0000_BEEF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(8'h00, r); check("R1 mask", r, 32'h0);
    rd(8'h04, r); check("R1 raw", r, 32'h0);
    rd(8'h08, r); check("R1 masked", r, 32'h0);
    rd(8'h14, r); check("R1 count", r, 32'h0);
    rd(8'h48, r); check("R1 ctrl", r, 32'h0);
    rd(8'h3C, r); check("R1 bg", r, 32'h0);

    // R2 map and readback table
    for (int i = 0; i < 12; i++) begin
      wr(VECS[i][79:72], VECS[i][71:40]);
      rd(VECS[i][39:32], r);
      check($sformatf("R2 vec%0d", i), r, VECS[i][31:0]);
    end

    // R3 countdown at divide by 1
    wr(8'h18, 0); wr(8'h10, 100); wr(8'h18, 32'h82);
    idle(10); rd(8'h14, r); check("R3 countdown", r, 32'd90);

    // R4 prescaler codes
    wr(8'h18, 0); wr(8'h10, 1000); wr(8'h18, 32'h86);
    idle(40); rd(8'h14, r); check("R4 div16", r, 32'd998);
    wr(8'h18, 0); wr(8'h10, 1000); wr(8'h18, 32'h8A);
    idle(600); rd(8'h14, r); check("R4 div256", r, 32'd998);
    wr(8'h18, 0); wr(8'h10, 1000); wr(8'h18, 32'h8E);
    idle(600); rd(8'h14, r); check("R4 code11", r, 32'd998);

    // R5 free-running wrap, 32 and 16 bit
    wr(8'h18, 0); wr(8'h10, 2); wr(8'h18, 32'h82);
    idle(3); rd(8'h14, r); check("R5 wrap32", r, 32'hFFFF_FFFF);
    rd(8'h04, r); check("R5 raw0", r & 32'h1, 32'h1);
    wr(8'h18, 0);
    wr(8'h28, 0); wr(8'h20, 2); wr(8'h28, 32'h80);
    idle(3); rd(8'h24, r); check("R5 wrap16", r, 32'h0000_FFFF);
    wr(8'h28, 0);

    // R6 periodic reload
    wr(8'h3C, 5); wr(8'h30, 1); wr(8'h38, 32'hC2);
    idle(2); rd(8'h34, r); check("R6 reload", r, 32'd5);
    rd(8'h04, r); check("R6 raw2", r & 32'h4, 32'h4);
    wr(8'h38, 0);

    // R7 background write leaves running count
    wr(8'h18, 0); wr(8'h10, 1000); wr(8'h18, 32'h82); wr(8'h1C, 7);
    rd(8'h14, r); check("R7 count kept", r, 32'd999);
    wr(8'h18, 0);
    rd(8'h1C, r); check("R7 bg", r, 32'd7);

    // R8 one-shot, and priority over periodic
    wr(8'h4C, 50); wr(8'h48, 0); wr(8'h40, 3); wr(8'h48, 32'h83);
    idle(10); rd(8'h44, r); check("R8 stop count", r, 32'h0);
    rd(8'h48, r); check("R8 enable cleared", r, 32'h03);
    rd(8'h04, r); check("R8 raw3", r & 32'h8, 32'h8);
    wr(8'h40, 3); wr(8'h48, 32'hC3);
    idle(10); rd(8'h44, r); check("R8 priority count", r, 32'h0);
    rd(8'h48, r); check("R8 priority ctrl", r, 32'h43);

    // R9 stop freezes count, load while stopped
    wr(8'h28, 0); wr(8'h20, 500); wr(8'h28, 32'h82);
    idle(5); wr(8'h28, 0);
    rd(8'h24, r); check("R9 frozen a", r, 32'd495);
    idle(20); rd(8'h24, r); check("R9 frozen b", r, 32'd495);
    wr(8'h20, 77); idle(3); rd(8'h24, r); check("R9 load stopped", r, 32'd77);

    // R10 mask and combined interrupt
    rd(8'h04, r); check("R10 raw all", r, 32'hF);
    idle(2); check("R10 irq masked off", {31'h0, irq}, 32'h0);
    rd(8'h08, r); check("R10 masked none", r, 32'h0);
    wr(8'h00, 4); idle(2);
    check("R10 irq on", {31'h0, irq}, 32'h1);
    rd(8'h08, r); check("R10 masked bit2", r, 32'h4);

    // R11 clear write-one
    wr(8'h0C, 4); idle(2);
    rd(8'h04, r); check("R11 raw after clear", r, 32'hB);
    check("R11 irq off", {31'h0, irq}, 32'h0);
    rd(8'h08, r); check("R11 masked after clear", r, 32'h0);
    wr(8'h0C, 32'hB);
    rd(8'h04, r); check("R11 raw empty", r, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule